// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small 8-bit accumulator processor. One operation code selects among shifts, rotates, increment and decrement, bitwise logic, add with carry, subtract with carry and compare. It takes two operands: the accumulator value and a second operand that holds a memory byte or an immediate. The result is combinational. It is ready in the same cycle the inputs are presented, so the sequencer can route it onto its own buses.

The negative, zero, carry and overflow flags are kept in a register inside the block. The current carry feeds the rotates and the add and subtract paths. Each flag has a write enable that depends on the operation class, and a flag register loads only on a clock edge where the operation strobe is high. The strobe is a plain control pin and there is no ready signal. Every operation finishes in one cycle, so the block never applies back-pressure and the sequencer may strobe on every clock.

Top module: `acc_alu_flags`

## Requirements
- R1: Codes 0 to 3 are shift left, logical shift right, rotate left and rotate right, and act on the second operand. The shifts bring in 0 and the rotates bring in the current carry. The bit shifted out becomes the new carry. N and Z are also updated and V is held.
- R2: Codes 4 to 8 are increment of the second operand, decrement of the second operand, AND, OR and XOR of the two operands. They update only N and Z, and C and V stay as they were.
- R3: Code 9 gives accumulator + operand + carry. C takes the carry out of bit 7. V is set when both operands have the same sign and the result sign differs from it.
- R4: Code 10 gives accumulator + inverted operand + carry, so C=1 means no borrow. V follows the R3 rule applied to the inverted operand.
- R5: Code 11 compares the accumulator against the operand. N and Z come from the 8-bit difference, C is set when the accumulator is at least the operand (unsigned), V is held, and the result output equals the accumulator.
- R6: Code 12 clears C and code 13 sets C, and neither touches N, Z or V. Codes 14 and 15 change no flag. For codes 12 to 15 the result output equals the accumulator.
- R7: Wherever N and Z are updated, Z is set for a zero 8-bit value and N copies bit 7. The one exception is logical shift right, which always clears N.
- R8: Flags change only on a rising clock edge where the strobe is high. The result output follows the inputs in the same cycle, whether or not the strobe is high.
- R9: While reset is asserted (active low) all four flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_strobe | input | 1 | Commit the flag update of the current operation |
| op_code | input | 4 | Operation select (codes as in R1-R6 text) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Memory or immediate operand |
| result | output | 8 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions assume the operation code and operands are stable and known while the strobe is high, and that reset is held for at least one clock edge. They make no assumption about the inputs while the strobe is low, because the flags must then hold whatever the inputs are. The stimulus drives every input just after a rising edge. Before each operation it sets the carry explicitly, then sweeps all sixteen codes across a grid of operand pairs that includes the zero, sign-boundary and all-ones values, with both carry states. It also presents operations with the strobe low to confirm that the flags hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W  = 8;
  localparam int FLAG_CT = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_RTL  = 4'd2,
    OP_RTR  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_ADD  = 4'd9,
    OP_SUB  = 4'd10,
    OP_CMP  = 4'd11,
    OP_CCLR = 4'd12,
    OP_CSET = 4'd13,
    OP_IDL0 = 4'd14,
    OP_IDL1 = 4'd15
  } alu_op_e;

  typedef logic [FLAG_CT-1:0] flag_vec_t;
endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] res,
  output flag_vec_t    fval
);
  localparam int MSB = W - 1;

  logic         use_inv;
  logic         add_cin;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [W-1:0] nz_src;
  logic         c_new;

  always_comb begin
    use_inv = (op == OP_SUB) || (op == OP_CMP);
    add_cin = (op == OP_CMP) ? 1'b1 : c_in;
  end

  assign b_eff = use_inv ? ~b : b;
  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, add_cin};

  always_comb begin
    res   = a;
    c_new = c_in;
    unique case (op)
      OP_SHL:  begin res = {b[MSB-1:0], 1'b0}; c_new = b[MSB]; end
      OP_SHR:  begin res = {1'b0, b[MSB:1]};   c_new = b[0];   end
      OP_RTL:  begin res = {b[MSB-1:0], c_in}; c_new = b[MSB]; end
      OP_RTR:  begin res = {c_in, b[MSB:1]};   c_new = b[0];   end
      OP_INC:  res = b + 1'b1;
      OP_DEC:  res = b - 1'b1;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ADD, OP_SUB: begin res = sum[MSB:0]; c_new = sum[W]; end
      OP_CMP:  c_new = sum[W];
      OP_CCLR: c_new = 1'b0;
      OP_CSET: c_new = 1'b1;
      default: res = a;
    endcase
  end

  assign nz_src = (op == OP_CMP) ? sum[MSB:0] : res;

  always_comb begin
    fval[FN] = (op == OP_SHR) ? 1'b0 : nz_src[MSB];
    fval[FZ] = (nz_src == '0);
    fval[FC] = c_new;
    fval[FV] = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/acc_alu_mask.sv
module acc_alu_mask
  import acc_alu_pkg::*;
(
  input  alu_op_e   op,
  output flag_vec_t wen
);
  always_comb begin
    wen = '0;
    unique case (op)
      OP_SHL, OP_SHR, OP_RTL, OP_RTR, OP_CMP: begin
        wen[FN] = 1'b1; wen[FZ] = 1'b1; wen[FC] = 1'b1;
      end
      OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR: begin
        wen[FN] = 1'b1; wen[FZ] = 1'b1;
      end
      OP_ADD, OP_SUB: wen = '1;
      OP_CCLR, OP_CSET: wen[FC] = 1'b1;
      default: wen = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  flag_vec_t wen,
  input  flag_vec_t dval,
  output flag_vec_t q
);
  for (genvar i = 0; i < FLAG_CT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                q[i] <= 1'b0;
      else if (strobe && wen[i]) q[i] <= dval[i];
    end
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_strobe,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  alu_op_e   op;
  flag_vec_t fq;
  flag_vec_t fnew;
  flag_vec_t fwen;

  assign op = alu_op_e'(op_code);

  acc_alu_core #(.W(DATA_W)) u_core (
    .op(op), .a(acc_in), .b(opnd_in), .c_in(fq[FC]), .res(result), .fval(fnew)
  );

  acc_alu_mask u_mask (.op(op), .wen(fwen));

  acc_alu_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .strobe(op_strobe), .wen(fwen), .dval(fnew), .q(fq)
  );

  assign flag_n = fq[FN];
  assign flag_z = fq[FZ];
  assign flag_c = fq[FC];
  assign flag_v = fq[FV];

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_strobe |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  assert_shr_clears_n_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && op_code == 4'd1) |=> !flag_n);

  assert_logic_keeps_cv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && op_code inside {[4'd4:4'd8]}) |=> $stable({flag_c, flag_v}));

  assert_cmp_keeps_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && op_code == 4'd11) |=> $stable(flag_v));

  assert_carry_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && op_code == 4'd12) |=> (!flag_c && $stable({flag_n, flag_z, flag_v})));

  assert_carry_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && op_code == 4'd13) |=> (flag_c && $stable({flag_n, flag_z, flag_v})));

  assert_zero_tracks_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && op_code <= 4'd10) |=> (flag_z == ($past(result) == '0)));
endmodule

// File: tb/acc_alu_flags_test.sv
module acc_alu_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_strobe = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] opnd_in = '0;
  logic [7:0] result;
  logic       flag_n, flag_z, flag_c, flag_v;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit en, ez, ec, ev;

  always #2 clk = ~clk;

  acc_alu_flags uut (.*);

  function automatic int pick(int i);
    case (i)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7F;
      3: return 8'h80;
      4: return 8'hFF;
      5: return 8'hFE;
      default: return (i * 53 + 11) & 255;
    endcase
  endfunction

  function automatic string tag(int op);
    if (op <= 3) return "R1";
    if (op <= 8) return "R2";
    if (op == 9) return "R3";
    if (op == 10) return "R4";
    if (op == 11) return "R5";
    return "R6";
  endfunction

  // Reference model: returns {res[7:0], n, z, c, v}
  function automatic logic [11:0] model(int op, int a, int m, bit n, bit z, bit c, bit v);
    int r = a;
    int t;
    int mm;
    bit upd_nz = 1;
    case (op)
      0: begin r = (m * 2) & 255; c = m >= 128; end
      1: begin r = m / 2; c = m % 2; end
      2: begin r = ((m * 2) & 255) + c; c = m >= 128; end
      3: begin r = m / 2 + (c ? 128 : 0); c = m % 2; end
      4: r = (m + 1) & 255;
      5: r = (m + 255) & 255;
      6: r = a & m;
      7: r = a | m;
      8: r = a ^ m;
      9, 10: begin
        mm = (op == 10) ? 255 - m : m;
        t = a + mm + c;
        r = t & 255;
        c = t > 255;
        v = ((a >= 128) == (mm >= 128)) && ((r >= 128) != (a >= 128));
      end
      11: begin
        t = (a - m) & 255;
        c = a >= m;
        n = t >= 128; z = t == 0;
        upd_nz = 0;
      end
      12: begin c = 0; upd_nz = 0; end
      13: begin c = 1; upd_nz = 0; end
      default: upd_nz = 0;
    endcase
    if (upd_nz) begin
      n = (op == 1) ? 1'b0 : (r >= 128);
      z = (r == 0);
    end
    return {r[7:0], n, z, c, v};
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(int op, int a, int m, bit strobe, bit chk);
    logic [11:0] e;
    op_code = op[3:0]; acc_in = a[7:0]; opnd_in = m[7:0]; op_strobe = strobe;
    e = model(op, a, m, en, ez, ec, ev);
    #2;
    if (chk) check({tag(op), "/R8 result"}, result, e[11:4]);
    @(posedge clk); #1;
    if (strobe) {en, ez, ec, ev} = e[3:0];
    if (chk) check({tag(op), "/R7 flags"}, {flag_n, flag_z, flag_c, flag_v}, {en, ez, ec, ev});
    op_strobe = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset flags", {flag_n, flag_z, flag_c, flag_v}, 0);
    {en, ez, ec, ev} = 4'b0;
    rst_n = 1'b1;

    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 16; ia++)
        for (int im = 0; im < 16; im++)
          for (int cin = 0; cin < 2; cin++) begin
            run_op(cin ? 13 : 12, 0, 0, 1'b1, 1'b0);
            run_op(op, pick(ia), pick(im), 1'b1, 1'b1);
          end

    // R8: strobe low leaves every flag untouched
    run_op(13, 0, 0, 1'b1, 1'b0);
    run_op(9, 8'h7F, 8'h01, 1'b1, 1'b1);
    for (int op = 0; op < 16; op++)
      run_op(op, 8'h00, 8'h80, 1'b0, 1'b1);

    // R3 signed overflow boundary and R4 borrow boundary
    run_op(12, 0, 0, 1'b1, 1'b0);
    run_op(9, 8'h80, 8'h80, 1'b1, 1'b1);
    run_op(13, 0, 0, 1'b1, 1'b0);
    run_op(10, 8'h00, 8'h01, 1'b1, 1'b1);
    run_op(10, 8'h80, 8'h01, 1'b1, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule